// File: doc/BRIEF.md
# Buffered 24-Line Parallel I/O Port Controller

This block drives 24 general-purpose digital lines from a byte-wide host bus. The lines form two 8-bit ports (A and B) and a third port C. Port C is split into an upper and a lower 4-bit nibble, and each nibble has its own direction. Only the simple latched-output / unlatched-input mode exists. There are no handshake or bit-set features.

A single control address sets the direction of every group. The same address also holds a global buffer-disable latch. A control write with bit 7 high loads new directions and tristates every pad at once. A later control write with bit 7 low only re-enables the pads. This lets the host change directions and preset output values while the pins stay quiet. When the pads are disabled, input lines read as all ones, which models the board pull-ups.

Top module: `pio24_ctrl`

## Requirements
- R1: Bus address 0 selects port A (pads 7:0), 1 selects port B (pads 15:8), 2 selects port C (pads 23:16, lower nibble in data bits 3:0 and upper nibble in data bits 7:4), and 3 selects the control register.
- R2: In the control byte, bit 4 sets the direction of port A, bit 3 of C upper, bit 1 of port B and bit 0 of C lower. A 1 selects input and a 0 selects output. Bits 2, 5 and 6 have no effect.
- R3: A control write with bit 7 set loads all four direction bits and disables every pad output enable from the next cycle on.
- R4: A control write with bit 7 clear re-enables the buffers and leaves all four direction bits unchanged.
- R5: A write to a port loads its output latch whatever the direction or buffer state, and pad_out shows the latch from the next cycle.
- R6: pad_oe for a line is 1 exactly when its group is set to output and the buffers are enabled.
- R7: Reading a port whose group is set to output returns the output latch value.
- R8: Reading a group set to input with the buffers enabled returns pad_in combinationally, with no latching.
- R9: While the buffers are disabled, lines of input-direction groups read as 1.
- R10: After reset, all groups are inputs, the buffers are enabled, the latches are zero and pad_oe is zero.
- R11: A read of address 3 returns the buffer-disable bit in bit 7 and the direction bits in positions 4, 3, 1 and 0, with zeros elsewhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register offset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for bus_addr |
| pad_in | input | 24 | Pad input levels |
| pad_out | output | 24 | Pad output values |
| pad_oe | output | 24 | Per-line output enables |

## Verification
The hardest state to reach is a split configuration. In it, some groups are outputs and others are inputs, the buffers are disabled, and the output latches are preset. From this state a bit-7-low write must re-enable the pins without disturbing the directions. The stimulus first writes a control byte with bit 7 set, mixed direction bits and the ignored bits 2, 5 and 6 set. It then presets port values while disabled, and only then sends an enable byte whose direction bits differ. Pad input changes are applied between clocks to show that input reads are live. A random phase then mixes writes and pad changes against the bench's reference model.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int BUS_W   = 8;
  localparam int OFS_W   = 2;
  localparam int B_OFF   = 7;
  localparam int B_DIR_A = 4;
  localparam int B_DIR_CU = 3;
  localparam int B_DIR_B = 1;
  localparam int B_DIR_CL = 0;

  typedef enum logic [OFS_W-1:0] {
    OFS_A   = 2'd0,
    OFS_B   = 2'd1,
    OFS_C   = 2'd2,
    OFS_CTL = 2'd3
  } ofs_e;

  typedef struct packed {
    logic a;
    logic cu;
    logic b;
    logic cl;
  } dir_t;
endpackage

// File: rtl/pio_cfg_reg.sv
module pio_cfg_reg
  import pio_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [BUS_W-1:0] wdata,
  output dir_t             dir,
  output logic             buf_off
);
  dir_t dir_d, dir_q;
  logic off_d, off_q;

  always_comb begin
    dir_d = dir_q;
    off_d = off_q;
    if (wr_en) begin
      off_d = wdata[B_OFF];
      if (wdata[B_OFF]) begin
        dir_d.a  = wdata[B_DIR_A];
        dir_d.cu = wdata[B_DIR_CU];
        dir_d.b  = wdata[B_DIR_B];
        dir_d.cl = wdata[B_DIR_CL];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '{a: 1'b1, cu: 1'b1, b: 1'b1, cl: 1'b1};
      off_q <= 1'b0;
    end else if (wr_en) begin
      dir_q <= dir_d;
      off_q <= off_d;
    end
  end

  assign dir     = dir_q;
  assign buf_off = off_q;

  // R3: a disabling write tristates the buffers
  a_r3_off_on_set: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wdata[B_OFF]) |=> buf_off);
  // R4: an enabling write keeps the directions
  a_r4_dir_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wdata[B_OFF]) |=> (!buf_off && $stable(dir)));
  // R3/R4: nothing moves without a control write
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(dir) && $stable(buf_off)));
endmodule

// File: rtl/pio_lane_grp.sv
module pio_lane_grp #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  input  logic         is_input,
  input  logic         buf_off,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_oe,
  output logic [W-1:0] rd_val
);
  logic [W-1:0] lat_d, lat_q;

  always_comb begin
    lat_d = lat_q;
    if (wr_en) lat_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     lat_q <= '0;
    else if (wr_en) lat_q <= lat_d;
  end

  always_comb begin
    pin_oe = {W{!is_input && !buf_off}};
    if (!is_input)   rd_val = lat_q;
    else if (buf_off) rd_val = '1;
    else             rd_val = pin_in;
  end

  assign pin_out = lat_q;

  // R5: latch only changes on a write
  a_r5_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(pin_out));
  // R7: driven lines read back what they drive
  a_r7_rd_driven: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe != '0) |-> (rd_val == pin_out));
endmodule

// File: rtl/pio24_ctrl.sv
module pio24_ctrl
  import pio_pkg::*;
#(
  parameter int PORT_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          bus_addr,
  input  logic                bus_wr,
  input  logic [7:0]          bus_wdata,
  output logic [7:0]          bus_rdata,
  input  logic [3*PORT_W-1:0] pad_in,
  output logic [3*PORT_W-1:0] pad_out,
  output logic [3*PORT_W-1:0] pad_oe
);
  localparam int NIB_W = PORT_W / 2;
  localparam int LINES = 3 * PORT_W;

  logic rst_s1, rst_s2;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  dir_t dir;
  logic buf_off;
  logic ctl_wr;
  logic [LINES-1:0] rd_lines;

  assign ctl_wr = bus_wr && (bus_addr == OFS_CTL);

  pio_cfg_reg i_cfg (
    .clk    (clk),
    .rst_n  (rst_s2),
    .wr_en  (ctl_wr),
    .wdata  (bus_wdata),
    .dir    (dir),
    .buf_off(buf_off)
  );

  for (genvar g = 0; g < 4; g++) begin : g_grp
    localparam int GW  = (g < 2) ? PORT_W : NIB_W;
    localparam int LSB = (g < 2) ? g * PORT_W : 2 * PORT_W + (g - 2) * NIB_W;
    localparam int DLSB = (g == 3) ? NIB_W : 0;
    logic grp_in;
    logic grp_wr;
    if (g == 0) begin : g_a
      assign grp_in = dir.a;
      assign grp_wr = bus_wr && (bus_addr == OFS_A);
    end else if (g == 1) begin : g_b
      assign grp_in = dir.b;
      assign grp_wr = bus_wr && (bus_addr == OFS_B);
    end else if (g == 2) begin : g_cl
      assign grp_in = dir.cl;
      assign grp_wr = bus_wr && (bus_addr == OFS_C);
    end else begin : g_cu
      assign grp_in = dir.cu;
      assign grp_wr = bus_wr && (bus_addr == OFS_C);
    end

    pio_lane_grp #(.W(GW)) i_lane (
      .clk     (clk),
      .rst_n   (rst_s2),
      .wr_en   (grp_wr),
      .wdata   (bus_wdata[DLSB +: GW]),
      .is_input(grp_in),
      .buf_off (buf_off),
      .pin_in  (pad_in[LSB +: GW]),
      .pin_out (pad_out[LSB +: GW]),
      .pin_oe  (pad_oe[LSB +: GW]),
      .rd_val  (rd_lines[LSB +: GW])
    );
  end

  always_comb begin
    unique case (ofs_e'(bus_addr))
      OFS_A:   bus_rdata = rd_lines[PORT_W-1:0];
      OFS_B:   bus_rdata = rd_lines[2*PORT_W-1:PORT_W];
      OFS_C:   bus_rdata = rd_lines[LINES-1:2*PORT_W];
      default: begin
        bus_rdata = '0;
        bus_rdata[B_OFF]    = buf_off;
        bus_rdata[B_DIR_A]  = dir.a;
        bus_rdata[B_DIR_CU] = dir.cu;
        bus_rdata[B_DIR_B]  = dir.b;
        bus_rdata[B_DIR_CL] = dir.cl;
      end
    endcase
  end

  // R6: no pad is driven while buffers are off
  a_r6_oe_gated: assert property (@(posedge clk) disable iff (!rst_s2)
    (pad_oe != '0) |-> !buf_off);
  // R3: after a disabling write every pad is released
  a_r3_pads_off: assert property (@(posedge clk) disable iff (!rst_s2)
    (ctl_wr && bus_wdata[B_OFF]) |=> (pad_oe == '0));
  // R10: immediately after reset release nothing is driven
  a_r10_quiet: assert property (@(posedge clk) disable iff (!rst_s2)
    $rose(rst_s2) |-> (pad_oe == '0));
endmodule

// File: tb/test_pio24_ctrl.sv
module test_pio24_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  bus_addr;
  logic        bus_wr;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;
  logic [23:0] pad_in;
  logic [23:0] pad_out;
  logic [23:0] pad_oe;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pio24_ctrl i_pio24_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe)
  );

  // reference model: directions per group index 0=A,1=B,2=CL,3=CU
  bit [3:0]  m_in;
  bit        m_off;
  bit [23:0] m_lat;

  function automatic int grp_of(int line);
    if (line < 8)  return 0;
    if (line < 16) return 1;
    if (line < 20) return 2;
    return 3;
  endfunction

  function automatic bit [23:0] exp_oe();
    bit [23:0] r;
    for (int i = 0; i < 24; i++) r[i] = !m_in[grp_of(i)] && !m_off;
    return r;
  endfunction

  function automatic bit [23:0] exp_lines();
    bit [23:0] r;
    for (int i = 0; i < 24; i++) begin
      if (!m_in[grp_of(i)]) r[i] = m_lat[i];
      else if (m_off)       r[i] = 1'b1;
      else                  r[i] = pad_in[i];
    end
    return r;
  endfunction

  function automatic bit [7:0] exp_rd(bit [1:0] a);
    bit [23:0] l = exp_lines();
    case (a)
      2'd0: return l[7:0];
      2'd1: return l[15:8];
      2'd2: return l[23:16];
      default: return {m_off, 2'b00, m_in[0], m_in[3], 1'b0, m_in[1], m_in[2]};
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_in <= 4'hF; m_off <= 1'b0; m_lat <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        2'd0: m_lat[7:0]   <= bus_wdata;
        2'd1: m_lat[15:8]  <= bus_wdata;
        2'd2: m_lat[23:16] <= bus_wdata;
        default: begin
          m_off <= bus_wdata[7];
          if (bus_wdata[7]) m_in <= {bus_wdata[3], bus_wdata[0], bus_wdata[1], bus_wdata[4]};
        end
      endcase
    end
  end

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  // cycle compare against the model
  always @(negedge clk) begin
    if (rst_n && cyc > 3) begin
      chk("R6 pad_oe", pad_oe, exp_oe());
      chk("R5 pad_out", pad_out, m_lat);
      chk("R1 bus_rdata", bus_rdata, exp_rd(bus_addr));
    end
  end

  task automatic wr(bit [1:0] a, bit [7:0] d);
    @(posedge clk); #1;
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(bit [1:0] a, output logic [7:0] d);
    bus_addr = a; #0.5;
    d = bus_rdata;
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
      end
    end
  end

  initial begin
    logic [7:0] d;
    rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0;
    pad_in = 24'hA5_3C_96;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk); #1;

    // R10 reset state
    chk("R10 oe", pad_oe, 24'h0);
    chk("R10 latch", pad_out, 24'h0);
    rd(2'd3, d); chk("R10 R11 ctl", d, 8'h1B);
    rd(2'd0, d); chk("R8 live A", d, 8'h96);

    // R3 disable and all outputs
    wr(2'd3, 8'h80);
    chk("R3 oe off", pad_oe, 24'h0);
    rd(2'd3, d); chk("R11 ctl", d, 8'h80);
    // R5 preset while disabled
    wr(2'd0, 8'h5A); wr(2'd1, 8'hC3); wr(2'd2, 8'h7E);
    chk("R5 preset", pad_out, 24'h7EC35A);
    chk("R5 still off", pad_oe, 24'h0);
    // R4 enable
    wr(2'd3, 8'h00);
    chk("R4 R6 all drive", pad_oe, 24'hFFFFFF);
    rd(2'd0, d); chk("R7 A latch", d, 8'h5A);
    rd(2'd2, d); chk("R7 C latch", d, 8'h7E);

    // R2 mixed, ignored bits 2,5,6 set: A in, CL in, B out, CU out
    wr(2'd3, 8'hF5);
    rd(2'd3, d); chk("R2 ctl", d, 8'h91);
    rd(2'd0, d); chk("R9 A pulled", d, 8'hFF);
    rd(2'd2, d); chk("R9 CL pulled", d, 8'h7F);
    rd(2'd1, d); chk("R7 B latch off", d, 8'hC3);
    // R4 enable byte with other direction bits: must not change dirs
    wr(2'd3, 8'h0F);
    rd(2'd3, d); chk("R4 dirs kept", d, 8'h11);
    chk("R4 R6 oe", pad_oe, 24'hF0FF00);
    // R8 live input
    pad_in = 24'h000012; rd(2'd0, d); chk("R8 A live1", d, 8'h12);
    pad_in = 24'h0000E7; rd(2'd0, d); chk("R8 A live2", d, 8'hE7);
    pad_in = 24'h030000; rd(2'd2, d); chk("R8 C mix", d, 8'h73);

    // random mix
    for (int k = 0; k < 400; k++) begin
      @(posedge clk); #1;
      bus_addr  = 2'($urandom_range(0, 3));
      bus_wr    = 1'($urandom_range(0, 1));
      bus_wdata = 8'($urandom);
      pad_in    = 24'($urandom);
    end
    @(posedge clk); #1 bus_wr = 1'b0;
    repeat (2) @(posedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule